// File: doc/BRIEF.md
# Trigger Activity and Coincidence Indicator

This block sits between two trigger pulse inputs and their outgoing copies. An active-low inhibit line that arrives without any clock relation is synchronised into the 60 MHz domain. While that line is high, both triggers pass straight through. While it is low, both outgoing triggers are held low. Only the gated triggers feed the status logic, so pulses blocked by the inhibit are never seen as activity.

The status logic drives two LEDs:

- **Green activity LED.** A rising edge on either gated trigger starts a hold window of `HOLD_TICKS` periods of the 1 kHz strobe; 5000 periods give five seconds. Reset starts the same window. During the window the green LED follows a synchronised copy of the slow blink clock. Once the window runs out, the LED is lit steadily.
- **Red coincidence LED.** The red LED is dark after reset. It lights when both gated triggers rise in the same clock cycle, and it stays lit until the next reset.

The green LED is governed by a two-state machine:

- `WIN_BLINK` is the reset state. In it, a trigger edge reloads the tick counter; a tick with no edge decrements it; and a tick that finds the counter at 1 moves the machine to `WIN_STEADY`.
- In `WIN_STEADY`, a trigger edge reloads the counter and returns the machine to `WIN_BLINK`.

The red LED is governed by a second machine:

- It starts in `FLT_CLEAR` and moves to `FLT_LATCHED` when a coincident edge occurs.
- It leaves `FLT_LATCHED` only through reset.

Top module: `trig_watch`

## Requirements
- R1: Each outgoing trigger `trig_o[k]` equals `trig_i[k]` while the synchronised inhibit level is high, and is 0 while it is low.
- R2: A change on `inhibit_n_i` reaches the gating after exactly `INH_STAGES` (3) rising clock edges, and the gating then follows `trig_i` combinationally.
- R3: Asynchronous reset clears every inhibit synchroniser stage, so `trig_o` is 00 during reset and afterwards until a high inhibit has propagated. Reset also darkens the red LED and puts the green machine in `WIN_BLINK` with a full window.
- R4: Trigger pulses blocked by the inhibit do not change either LED.
- R5: In `WIN_BLINK` the green LED equals `blink_clk_i` delayed by `BLINK_STAGES` (2) clock edges. After `HOLD_TICKS` strobes on `tick_1k_i` with no trigger edge, the machine enters `WIN_STEADY` and the green LED is 1 whatever the blink clock does.
- R6: A rising edge on either gated trigger reloads the window to a full `HOLD_TICKS` and enters or stays in `WIN_BLINK` at the next clock edge. When an edge and a tick coincide, the reload wins.
- R7: Rising edges on both gated triggers in the same cycle light the red LED from the next clock edge until reset. Edges on the two triggers in different cycles do not light it.
- R8: Only rising edges count: a trigger held high does not restart the window again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 60 MHz clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| tick_1k_i | input | 1 | One-cycle strobe at 1 kHz, synchronous to clk_i |
| blink_clk_i | input | 1 | Slow blink square wave, asynchronous |
| trig_i | input | 2 | Raw trigger inputs |
| inhibit_n_i | input | 1 | Asynchronous inhibit, low blocks the triggers |
| trig_o | output | 2 | Gated triggers |
| led_green_o | output | 1 | Activity LED drive |
| led_red_o | output | 1 | Coincidence LED drive |

## Verification
Each result is due at a fixed number of clock edges after its stimulus:

- A new inhibit level appears on `trig_o` after the third edge.
- A blink level appears on the green LED after the second edge.
- A trigger edge changes the state of either LED at the first edge after it.
- A tick moves the window counter at the edge on which it is sampled.

The bench drives inputs on falling edges and advances a known number of rising edges before each check. It then samples on the following falling edge, so every check lands exactly on the cycle where the result appears. The latency checks also sample one edge early and expect the old value. The window is swept one tick at a time, with a reduced `HOLD_TICKS`, to confirm the exact tick on which the LED turns steady.

// File: rtl/trigwatch_pkg.sv
package trigwatch_pkg;

    typedef enum logic {
        WIN_BLINK  = 1'b0,
        WIN_STEADY = 1'b1
    } win_state_t;

    typedef enum logic {
        FLT_CLEAR   = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

    initial begin
        a_r2_stage_count: assert (STAGES >= 2);
    end
endmodule

// File: rtl/tw_edge.sv
module tw_edge #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= level_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = level_i[g] & ~prev_q[g];

        // R8: a level that was already high one cycle ago is not an edge
        a_r8_level_no_edge: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(level_i[g]) |-> !rise_o[g]);
    end
endmodule

// File: rtl/tw_window.sv
module tw_window
    import trigwatch_pkg::*;
#(
    parameter int HOLD_TICKS = 5000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic tick_i,
    input  logic blink_i,
    output logic green_o
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_TICKS);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    win_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WIN_BLINK: begin
                if (restart_i) begin
                    cnt_d = HOLD_LOAD;
                end else if (tick_i) begin
                    if (cnt_q == CNT_ONE) begin
                        state_d = WIN_STEADY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
            end
            WIN_STEADY: begin
                if (restart_i) begin
                    state_d = WIN_BLINK;
                    cnt_d   = HOLD_LOAD;
                end
            end
            default: begin
                state_d = WIN_BLINK;
                cnt_d   = HOLD_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= WIN_BLINK;
            cnt_q   <= HOLD_LOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            WIN_STEADY: green_o = 1'b1;
            default:    green_o = blink_i;
        endcase
    end

    // R6: an edge reloads the full window at the next clock
    a_r6_restart_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (state_q == WIN_BLINK && cnt_q == HOLD_LOAD));
    // R5: steady persists without an edge
    a_r5_steady_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WIN_STEADY && !restart_i) |=> state_q == WIN_STEADY);
    // R5: the window cannot end without a tick
    a_r5_no_tickless_exit: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WIN_BLINK && !tick_i) |=> state_q == WIN_BLINK);
    // R5: the blink phase always has ticks left
    a_r5_blink_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == WIN_BLINK |-> cnt_q != '0);
endmodule

// File: rtl/tw_fault.sv
module tw_fault
    import trigwatch_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] rise_i,
    output logic       red_o
);
    flt_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR:   if (&rise_i) state_d = FLT_LATCHED;
            FLT_LATCHED: state_d = FLT_LATCHED;
            default:     state_d = FLT_CLEAR;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= FLT_CLEAR;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLT_LATCHED: red_o = 1'b1;
            default:     red_o = 1'b0;
        endcase
    end

    // R7: once lit, the red LED stays lit until reset
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        red_o |=> red_o);
    // R7: the red LED only lights after a coincident edge pair
    a_r7_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(red_o) |-> $past(rise_i == 2'b11));
endmodule

// File: rtl/trig_watch.sv
module trig_watch #(
    parameter int INH_STAGES   = 3,
    parameter int BLINK_STAGES = 2,
    parameter int HOLD_TICKS   = 5000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_1k_i,
    input  logic       blink_clk_i,
    input  logic [1:0] trig_i,
    input  logic       inhibit_n_i,
    output logic [1:0] trig_o,
    output logic       led_green_o,
    output logic       led_red_o
);
    localparam int RUN_W = $clog2(INH_STAGES + 1);

    logic       pass_s;
    logic       blink_s;
    logic [1:0] rise_s;

    tw_sync #(.STAGES(INH_STAGES)) u_inh_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (inhibit_n_i),
        .q_o   (pass_s)
    );

    tw_sync #(.STAGES(BLINK_STAGES)) u_blink_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (blink_clk_i),
        .q_o   (blink_s)
    );

    assign trig_o = trig_i & {2{pass_s}};

    tw_edge #(.N(2)) u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (trig_o),
        .rise_o  (rise_s)
    );

    tw_window #(.HOLD_TICKS(HOLD_TICKS)) u_window (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (|rise_s),
        .tick_i    (tick_1k_i),
        .blink_i   (blink_s),
        .green_o   (led_green_o)
    );

    tw_fault u_fault (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rise_i (rise_s),
        .red_o  (led_red_o)
    );

    // Checker state: consecutive edges with the inhibit line sampled low
    logic [RUN_W-1:0] low_run_q;
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)                                   low_run_q <= '0;
        else if (inhibit_n_i)                        low_run_q <= '0;
        else if (low_run_q != RUN_W'(INH_STAGES))    low_run_q <= low_run_q + 1'b1;
    end

    // R1: a low inhibit held through the synchroniser blocks both triggers
    a_r1_inhibited_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (low_run_q == RUN_W'(INH_STAGES)) |-> trig_o == 2'b00);
    // R1: gating never creates a pulse that is absent at the input
    a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig_o & ~trig_i) == 2'b00);
endmodule

// File: tb/trig_watch_test.sv
module trig_watch_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       tick = 1'b0;
    logic       blink = 1'b0;
    logic [1:0] trig = 2'b00;
    logic       inh_n = 1'b0;
    logic [1:0] trig_o;
    logic       green, red;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    trig_watch #(.INH_STAGES(3), .BLINK_STAGES(2), .HOLD_TICKS(HOLD)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_1k_i   (tick),
        .blink_clk_i (blink),
        .trig_i      (trig),
        .inhibit_n_i (inh_n),
        .trig_o      (trig_o),
        .led_green_o (green),
        .led_red_o   (red)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic one_tick();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1 rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        // R3: reset state
        chk("R3 trig_o after reset", trig_o, 2'b00);
        chk("R3 red after reset", {1'b0, red}, 2'b00);
        chk("R3 green blinking (blink low)", {1'b0, green}, 2'b00);

        // R1/R4: inhibited inputs blocked, no coincidence seen
        trig = 2'b11;
        step(1);
        chk("R1 inhibited gating", trig_o, 2'b00);
        step(1);
        chk("R4 inhibited pair ignored", {1'b0, red}, 2'b00);
        trig = 2'b00;

        // R5: blink clock reaches green after two edges
        blink = 1'b1;
        step(1);
        chk("R5 blink one edge early", {1'b0, green}, 2'b00);
        step(1);
        chk("R5 blink after two edges", {1'b0, green}, 2'b01);
        blink = 1'b0;
        step(2);
        chk("R5 blink low again", {1'b0, green}, 2'b00);

        // R2: inhibit release latency, then R1 pass-through
        inh_n = 1'b1;
        trig  = 2'b01;
        step(2);
        chk("R2 gate still closed after two edges", trig_o, 2'b00);
        step(1);
        chk("R2 gate open after three edges", trig_o, 2'b01);
        step(1);        // rise of channel 0 reloads the window
        trig = 2'b00;
        step(1);
        chk("R1 pass-through low", trig_o, 2'b00);

        // R5: sweep ticks across the whole window
        for (int k = 1; k <= HOLD; k++) begin
            one_tick();
            chk($sformatf("R5 green after tick %0d", k), {1'b0, green},
                {1'b0, (k == HOLD)});
        end
        blink = 1'b1;
        step(2);
        chk("R5 steady ignores blink high", {1'b0, green}, 2'b01);
        blink = 1'b0;
        step(2);
        chk("R5 steady ignores blink low", {1'b0, green}, 2'b01);

        // R6: restart on channel 1, then restart coinciding with a tick
        trig = 2'b10;
        step(1);
        trig = 2'b00;
        chk("R6 edge returns to blink", {1'b0, green}, 2'b00);
        for (int k = 1; k < HOLD; k++) one_tick();
        chk("R6 one tick left", {1'b0, green}, 2'b00);
        trig = 2'b01;
        tick = 1'b1;
        step(1);
        trig = 2'b00;
        tick = 1'b0;
        chk("R6 reload wins over tick", {1'b0, green}, 2'b00);
        for (int k = 1; k < HOLD; k++) one_tick();
        chk("R6 full window after reload", {1'b0, green}, 2'b00);
        one_tick();
        chk("R6 window ends", {1'b0, green}, 2'b01);
        chk("R7 single edges leave red off", {1'b0, red}, 2'b00);

        // R8: a held level restarts only once
        trig = 2'b01;
        step(1);
        chk("R8 first edge restarts", {1'b0, green}, 2'b00);
        for (int k = 1; k <= HOLD; k++) one_tick();
        chk("R8 held level no retrigger", {1'b0, green}, 2'b01);
        trig = 2'b00;

        // R4: inhibited pulses are not activity
        inh_n = 1'b0;
        step(3);
        trig = 2'b01;
        step(1);
        chk("R4 gated low while inhibited", trig_o, 2'b00);
        trig = 2'b00;
        step(1);
        chk("R4 inhibited pulse no restart", {1'b0, green}, 2'b01);
        trig = 2'b11;
        step(1);
        trig = 2'b00;
        step(1);
        chk("R4 inhibited pair no red", {1'b0, red}, 2'b00);

        // R7: staggered edges then a coincident pair
        inh_n = 1'b1;
        step(3);
        trig = 2'b01;
        step(1);
        trig = 2'b11;
        step(1);
        chk("R7 staggered edges", {1'b0, red}, 2'b00);
        trig = 2'b00;
        step(1);
        trig = 2'b11;
        step(1);
        chk("R7 coincident edges light red", {1'b0, red}, 2'b01);
        trig = 2'b00;
        step(5);
        chk("R7 red latched", {1'b0, red}, 2'b01);

        // R3: reset clears red and synchroniser
        trig = 2'b01;
        rst  = 1'b1;
        #1;
        chk("R3 red cleared by reset", {1'b0, red}, 2'b00);
        chk("R3 gate closed in reset", trig_o, 2'b00);
        step(1);
        rst = 1'b0;
        step(2);
        chk("R3 gate closed until propagated", trig_o, 2'b00);
        step(1);
        chk("R2 gate reopens after three edges", trig_o, 2'b01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule